// File: doc/BRIEF.md
# Dual-Lane Polling and Status-Read Scheduler

This block issues the periodic request strobes that a side-channel link engine needs on two lanes. Two kinds of request exist: a poll and a status read. Each kind has its own interval. An interval is set by a two-bit upper field and an eight-bit lower field, and its length is scaled by a shared prescaler that divides the free-running oscillator clock. An interval whose two fields are both zero switches that kind of request off.

Each lane passes or blocks each kind of strobe through three enables: a lane enable, a poll enable and a status enable. When the stagger input is set, the lane 1 poll is delayed by a quarter of the poll interval, so the two lanes never poll in the same cycle. A poll and a status read can fall due on the same lane in the same cycle. The poll then goes out first and the status read follows one cycle later. Every output is a one-cycle pulse. A new interval setting does not cut short the period already running. It is picked up at the next interval boundary.

In the chip the oscillator clock is `clk`, so one clock cycle is one oscillator tick. The interval fields are expected to come from configuration registers elsewhere. The recommended values there are a poll lower field of 124 and a status lower field of 249, with both upper fields 0. The smallest recommended poll count is 24 (0x018).

Top module: `poll_ssr_sched`

## Requirements
- R1: With poll count N = 256*poll_up + poll_dn + 1 (not both fields zero) and prescale P, lane 0 pulses poll_req[0] in cycle N*P-1 after reset release (cycle 0 being the first cycle out of reset) and then every N*P cycles.
- R2: When poll_up and poll_dn are both 0, no poll strobe appears on either lane.
- R3: Status strobes follow the same count formula using ssr_up and ssr_dn, appear on both lanes in the same cycle, and stop when both of those fields are 0.
- R4: Bit l of lane_en, poll_en and ssr_en belongs to lane l (bit 0 is lane 0, bit 1 is lane 1). poll_req[l] pulses only when lane_en[l] and poll_en[l] are both 1. ssr_req[l] pulses only when lane_en[l] and ssr_en[l] are both 1. A disabled strobe does not shift the timing of the other lane or of the other kind of strobe.
- R5: With stagger_en=0, both lanes poll in the same cycle. With stagger_en=1, each lane 1 poll comes N*P/4 cycles after the lane 0 poll that precedes it.
- R6: Every strobe is high for a single cycle at a time.
- R7: If a poll and a status read fall due on the same lane in the same cycle, poll_req goes out in that cycle and ssr_req goes out in the next cycle. The two never go high together on one lane.
- R8: A change to poll_up or poll_dn during an interval does not cut that interval short. The new count applies from the next poll boundary onward.
- R9: While rst is high, and in the cycle after it, every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one cycle is one tick |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | 2 | Per-lane master enable |
| poll_en | input | 2 | Per-lane poll enable |
| ssr_en | input | 2 | Per-lane status-read enable |
| stagger_en | input | 1 | Delay the lane 1 poll by a quarter interval |
| poll_up | input | 2 | Poll count, upper field (weight 256) |
| poll_dn | input | 8 | Poll count, lower field |
| ssr_up | input | 2 | Status-read count, upper field (weight 256) |
| ssr_dn | input | 8 | Status-read count, lower field |
| poll_req | output | 2 | Per-lane poll strobe |
| ssr_req | output | 2 | Per-lane status-read strobe |

## Verification
A wrong prescaler or interval counter moves the first strobe away from cycle N*P-1 and shows up at the very first pulse. A wrongly latched period shows up one boundary after a change of the interval fields. A stale stagger delay puts the lane 1 poll a wrong number of cycles after the lane 0 poll within one interval. A pending status read that is lost or duplicated shows up in the cycle right after a collision: ssr_req is missing there, or it appears together with poll_req. Sweeping small counts at a prescale of 4 makes every one of these visible within a few dozen cycles.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int UP_W  = 2;
    localparam int DN_W  = 8;
    localparam int CNT_W = UP_W + DN_W + 1;
    localparam int NLANE = 2;
    localparam int NKIND = 2;
    localparam int KIND_POLL = 0;
    localparam int KIND_SSR  = 1;

    typedef struct packed {
        logic [UP_W-1:0] up;
        logic [DN_W-1:0] dn;
    } ival_cfg_t;

    typedef logic [CNT_W-1:0] ival_cnt_t;

    // Interval length in prescaled ticks; zero means switched off.
    function automatic ival_cnt_t ival_count(ival_cfg_t c);
        if (c.up == '0 && c.dn == '0)
            return '0;
        return (ival_cnt_t'(c.up) << DN_W) + ival_cnt_t'(c.dn) + ival_cnt_t'(1);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + PW'(1);
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import sched_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  ival_cfg_t cfg,
    output logic      due
);
    ival_cnt_t period;
    ival_cnt_t cnt;
    logic      at_end;

    assign at_end = (period == '0) || (cnt == period - ival_cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= ival_count(cfg);
            cnt    <= '0;
        end else if (tick) begin
            if (at_end) begin
                period <= ival_count(cfg);
                cnt    <= '0;
            end else begin
                cnt <= cnt + ival_cnt_t'(1);
            end
        end
    end

    assign due = tick && (period != '0) && (cnt == period - ival_cnt_t'(1));
endmodule

// File: rtl/lane_stagger.sv
module lane_stagger
    import sched_pkg::*;
#(
    parameter int PRESCALE = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      lead_due,
    input  ival_cnt_t next_count,
    output logic      lag_due
);
    localparam int QSTEP = PRESCALE / 4;
    localparam int QW    = CNT_W + $clog2(QSTEP + 1) + 1;

    logic [QW-1:0] remain;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            armed  <= 1'b0;
            remain <= '0;
        end else if (lead_due) begin
            armed  <= (next_count != '0);
            remain <= QW'(next_count) * QW'(QSTEP);
        end else if (armed) begin
            remain <= remain - QW'(1);
            if (remain == QW'(1))
                armed <= 1'b0;
        end
    end

    assign lag_due = armed && (remain == QW'(1));
endmodule

// File: rtl/strobe_arbiter.sv
module strobe_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic poll_due,
    input  logic poll_ok,
    input  logic ssr_due,
    input  logic ssr_ok,
    output logic poll_req,
    output logic ssr_req
);
    logic pg, sg, pend;

    assign pg = poll_due && poll_ok;
    assign sg = ssr_due && ssr_ok;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else
            pend <= sg && pg;
    end

    assign poll_req = pg;
    assign ssr_req  = ((sg && !pg) || pend) && ssr_ok;
endmodule

// File: rtl/poll_ssr_sched.sv
module poll_ssr_sched
    import sched_pkg::*;
#(
    parameter int PRESCALE = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      lane_en,
    input  logic [1:0]      poll_en,
    input  logic [1:0]      ssr_en,
    input  logic            stagger_en,
    input  logic [UP_W-1:0] poll_up,
    input  logic [DN_W-1:0] poll_dn,
    input  logic [UP_W-1:0] ssr_up,
    input  logic [DN_W-1:0] ssr_dn,
    output logic [1:0]      poll_req,
    output logic [1:0]      ssr_req
);
    logic             pre_tick;
    ival_cfg_t        cfg [NKIND];
    logic [NKIND-1:0] due;
    logic             lag_due;
    logic [NLANE-1:0] lane_poll;

    assign cfg[KIND_POLL] = '{up: poll_up, dn: poll_dn};
    assign cfg[KIND_SSR]  = '{up: ssr_up,  dn: ssr_dn};

    tick_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (pre_tick)
    );

    for (genvar k = 0; k < NKIND; k++) begin : g_tmr
        interval_timer u_tmr (
            .clk  (clk),
            .rst  (rst),
            .tick (pre_tick),
            .cfg  (cfg[k]),
            .due  (due[k])
        );
    end

    lane_stagger #(.PRESCALE(PRESCALE)) u_stg (
        .clk        (clk),
        .rst        (rst),
        .enable     (stagger_en),
        .lead_due   (due[KIND_POLL]),
        .next_count (ival_count(cfg[KIND_POLL])),
        .lag_due    (lag_due)
    );

    assign lane_poll[0] = due[KIND_POLL];
    assign lane_poll[1] = stagger_en ? lag_due : due[KIND_POLL];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        strobe_arbiter u_arb (
            .clk      (clk),
            .rst      (rst),
            .poll_due (lane_poll[l]),
            .poll_ok  (lane_en[l] && poll_en[l]),
            .ssr_due  (due[KIND_SSR]),
            .ssr_ok   (lane_en[l] && ssr_en[l]),
            .poll_req (poll_req[l]),
            .ssr_req  (ssr_req[l])
        );
    end
endmodule

// File: rtl/poll_ssr_sched_chk.sv
module poll_ssr_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lane_en,
    input logic [1:0] poll_en,
    input logic [1:0] ssr_en,
    input logic [1:0] poll_req,
    input logic [1:0] ssr_req
);
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (poll_req == 2'b00 && ssr_req == 2'b00));

    for (genvar l = 0; l < 2; l++) begin : g_l
        assert_poll_single_R6: assert property (@(posedge clk) disable iff (rst)
            poll_req[l] |=> !poll_req[l]);
        assert_ssr_single_R6: assert property (@(posedge clk) disable iff (rst)
            ssr_req[l] |=> !ssr_req[l]);
        assert_no_clash_R7: assert property (@(posedge clk) disable iff (rst)
            !(poll_req[l] && ssr_req[l]));
        assert_poll_gate_R4: assert property (@(posedge clk) disable iff (rst)
            !(lane_en[l] && poll_en[l]) |-> !poll_req[l]);
        assert_ssr_gate_R4: assert property (@(posedge clk) disable iff (rst)
            !(lane_en[l] && ssr_en[l]) |-> !ssr_req[l]);
    end
endmodule

bind poll_ssr_sched poll_ssr_sched_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .lane_en  (lane_en),
    .poll_en  (poll_en),
    .ssr_en   (ssr_en),
    .poll_req (poll_req),
    .ssr_req  (ssr_req)
);

// File: tb/tb_poll_ssr_sched.sv
`timescale 1ns/1ps
module tb_poll_ssr_sched;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lane_en = 2'b11, poll_en = 2'b11, ssr_en = 2'b11;
    logic       stagger_en = 1'b0;
    logic [1:0] poll_up = '0, ssr_up = '0;
    logic [7:0] poll_dn = '0, ssr_dn = '0;
    logic [1:0] poll_req, ssr_req;

    int checks = 0;
    int errors = 0;

    poll_ssr_sched #(.PRESCALE(P)) dut (
        .clk(clk), .rst(rst), .lane_en(lane_en), .poll_en(poll_en),
        .ssr_en(ssr_en), .stagger_en(stagger_en), .poll_up(poll_up),
        .poll_dn(poll_dn), .ssr_up(ssr_up), .ssr_dn(ssr_dn),
        .poll_req(poll_req), .ssr_req(ssr_req));

    always #10 clk = ~clk;

    function automatic int cnt_of(input int up, input int dn);
        if (up == 0 && dn == 0) return 0;
        return 256 * up + dn + 1;
    endfunction

    task automatic check(input string tag, input int cyc,
                         input logic [1:0] gp, input logic [1:0] ep,
                         input logic [1:0] gs, input logic [1:0] es);
        checks++;
        if (gp !== ep || gs !== es) begin
            errors++;
            $display("FAIL %s cycle %0d poll got %b exp %b ssr got %b exp %b",
                     tag, cyc, gp, ep, gs, es);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R9 reset", -1, poll_req, 2'b00, ssr_req, 2'b00);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_cfg(input int pu, input int pd, input int su, input int sd,
                           input logic ofs, input logic [1:0] le, input logic [1:0] pe,
                           input logic [1:0] se, input int ncyc, input string tag);
        int np, ns, tp, ts, q;
        logic [1:0] pend, prev_p, prev_s;
        logic dbl;
        poll_up = 2'(pu); poll_dn = 8'(pd); ssr_up = 2'(su); ssr_dn = 8'(sd);
        stagger_en = ofs; lane_en = le; poll_en = pe; ssr_en = se;
        np = cnt_of(pu, pd); ns = cnt_of(su, sd);
        tp = np * P; ts = ns * P; q = tp / 4;
        pend = 2'b00; prev_p = 2'b00; prev_s = 2'b00; dbl = 1'b0;
        do_reset();
        for (int c = 0; c < ncyc; c++) begin
            logic [1:0] rp, ep, es;
            logic rs;
            #1;
            rp[0] = (np != 0) && ((c + 1) % tp == 0);
            if (ofs)
                rp[1] = (np != 0) && (c + 1 - q >= tp) && ((c + 1 - q) % tp == 0);
            else
                rp[1] = rp[0];
            rs = (ns != 0) && ((c + 1) % ts == 0);
            for (int l = 0; l < 2; l++) begin
                logic pg, sg;
                pg = rp[l] && le[l] && pe[l];
                sg = rs && le[l] && se[l];
                ep[l] = pg;
                es[l] = (sg && !pg) || pend[l];
                pend[l] = sg && pg;
            end
            check(tag, c, poll_req, ep, ssr_req, es);
            if ((poll_req & prev_p) != 0 || (ssr_req & prev_s) != 0) dbl = 1'b1;
            prev_p = poll_req; prev_s = ssr_req;
            @(negedge clk);
        end
        checks++;
        if (dbl) begin
            errors++;
            $display("FAIL R6 strobe held two cycles got 1 exp 0 (%s)", tag);
        end
    endtask

    function automatic string pick_tag(int pat, int ofs, int pn, int sn);
        if (pat != 0) return "R4 gating";
        if (ofs != 0) return "R5 stagger";
        if (pn == 0)  return "R2 poll off";
        if (sn == 0)  return "R1 poll only";
        return "R3_R7 ssr/priority";
    endfunction

    initial begin
        #3_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired got hang exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Sweep of small counts, stagger and enable patterns (R1..R7)
        for (int pn = 0; pn <= 4; pn++)
            for (int sn = 0; sn <= 4; sn++)
                for (int ofs = 0; ofs <= 1; ofs++)
                    for (int pat = 0; pat <= 3; pat++) begin
                        logic [1:0] le, pe, se;
                        int mx;
                        le = (pat == 1) ? 2'b01 : 2'b11;
                        pe = (pat == 2) ? 2'b10 : 2'b11;
                        se = (pat == 3) ? 2'b10 : 2'b11;
                        mx = (pn > sn) ? pn : sn;
                        run_cfg(0, (pn > 0) ? pn - 1 : 0, 0, (sn > 0) ? sn - 1 : 0,
                                1'(ofs), le, pe, se, 3 * mx * P + pn + 6,
                                pick_tag(pat, ofs, pn, sn));
                    end

        // Upper field weight: N = 256 + 3 + 1 = 260, interval 1040 cycles (R1)
        run_cfg(1, 3, 0, 0, 1'b0, 2'b11, 2'b11, 2'b11, 2200, "R1 upper field");
        // Upper field on status read: N = 257, interval 1028 cycles (R3)
        run_cfg(0, 0, 1, 0, 1'b0, 2'b11, 2'b11, 2'b11, 2100, "R3 upper field");

        // R8: interval 16 cycles running, change to 8 cycles at cycle 5
        poll_up = '0; poll_dn = 8'd3; ssr_up = '0; ssr_dn = '0;
        stagger_en = 1'b0; lane_en = 2'b11; poll_en = 2'b11; ssr_en = 2'b11;
        do_reset();
        for (int c = 0; c < 42; c++) begin
            logic hit;
            #1;
            hit = (c == 15) || (c == 23) || (c == 31) || (c == 39);
            check("R8 reload at boundary", c, poll_req, {hit, hit}, ssr_req, 2'b00);
            if (c == 5) poll_dn = 8'd1;
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule